// File: doc/BRIEF.md
# Calendar Tick Counter

This block keeps the time of day and the calendar date of a real-time clock. Each pulse on the one-second tick input advances the seconds field. Any overflow then carries through minutes, hours, day of week, day of month, month, year and century. A mode input selects how every field is encoded: packed two-digit BCD or plain binary. A second mode input selects a 24-hour dial or a 12-hour dial with a PM flag.

Software or a bus front end sets the clock through a single-field load port. A load always wins over a tick that arrives in the same cycle. The century value appears on two outputs that always carry the same byte, so both legacy locations that read the century stay consistent.

The month table has no leap years, so February always has 28 days. Alarms, interrupts and daylight saving are handled elsewhere.

Top module: `cal_tick_counter`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hour 0x00, weekday 0x01, day 0x01, month 0x01, year 0x08, and both century outputs 0x20.
- R2: In a cycle with neither a tick nor a load, every output holds its value.
- R3: A tick increments seconds. When seconds reach 60 they return to 0 and carry into minutes. Minutes wrap the same way and carry into the hour.
- R4: With bin_mode_i=0 (BCD), an increment sets a low nibble of 9 to 0 and carries into the high nibble. For example 0x09 becomes 0x10 and 0x59 wraps to 0x00.
- R5: With bin_mode_i=1 (binary), an increment is a plain +1. For example 9 becomes 0x0A and 59 wraps to 0.
- R6: With h24_i=1, the hour counts 0 to 23. A carry out of 23 sets the hour to 0 and raises a day carry.
- R7: With h24_i=0, bit 7 of the hour is the PM flag and bits 6:0 hold 0 to 11. A carry out of 11 AM gives 0x80. A carry out of 11 PM gives 0x00 and raises a day carry.
- R8: On a day carry the weekday counts 0 to 6 and wraps from 6 to 0.
- R9: A month has 31 days for months 1, 3, 5, 7, 8, 10 and 12, 30 days for months 4, 6, 9 and 11, 28 days for month 2, and 30 days for any other value. On a day carry, a day equal to the month length becomes 1 and the month increments. Any other day increments.
- R10: Month 12 rolls to 1 and increments the year. Year 99 rolls to 0 and increments the century on both century outputs.
- R11: When ld_en_i=1, ld_data_i is written to the field chosen by ld_sel_i (0 seconds, 1 minutes, 2 hour, 3 weekday, 4 day, 5 month, 6 year, 7 century). A tick in that cycle is dropped, and every other field holds.
- R12: The two century outputs are always equal. A century load writes both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_i | input | 1 | 1 = 24-hour dial, 0 = 12-hour dial with PM flag |
| ld_en_i | input | 1 | Field load strobe |
| ld_sel_i | input | 3 | Field to load |
| ld_data_i | input | 8 | Value to load |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour, bit 7 PM in 12-hour mode |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| cent_o | output | 8 | Century |
| cent_alt_o | output | 8 | Century mirror |

## Verification
The hardest state to reach is a single tick that ripples through every field into the century. From reset it would need about a hundred years of ticks. The stimulus instead loads each field to its last legal value: 59, 59, 23 or 11 PM, the month length, 12, 99. A tick then checks the full cascade in each encoding. The random phases bias loads toward these edge values, so partial cascades such as minute-into-hour and month-end in short months appear often, in every combination of the two mode inputs.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FW   = 8;   // bits per calendar field
  localparam int NF   = 8;   // number of stored fields
  localparam int SELW = $clog2(NF);

  typedef enum logic [SELW-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_MDAY = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6,
    F_CENT = 3'd7
  } fld_e;

  // numeric value of a field in the active encoding
  function automatic int fld_to_int(logic [FW-1:0] v, logic bin);
    if (bin) return int'(v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  // encode a small number in the active encoding
  function automatic logic [FW-1:0] int_to_fld(int n, logic bin);
    logic [FW-1:0] r;
    if (bin) r = 8'(n);
    else     r = {4'(n / 10), 4'(n % 10)};
    return r;
  endfunction

  // bcd increment with nibble adjust; returns {carry, value}
  function automatic logic [FW:0] bcd_inc(logic [FW-1:0] v);
    logic [3:0] lo;
    logic [3:0] hi;
    logic       c;
    lo = v[3:0];
    hi = v[7:4];
    c  = 1'b0;
    if (lo >= 4'd9) begin
      lo = 4'd0;
      if (hi >= 4'd9) begin
        hi = 4'd0;
        c  = 1'b1;
      end else begin
        hi = hi + 4'd1;
      end
    end else begin
      lo = lo + 4'd1;
    end
    return {c, hi, lo};
  endfunction

  function automatic logic [FW-1:0] step_val(logic [FW-1:0] v, logic bin);
    logic [FW:0] t;
    if (bin) t = {1'b0, v} + 9'd1;
    else     t = bcd_inc(v);
    return t[FW-1:0];
  endfunction

  function automatic logic step_cy(logic [FW-1:0] v, logic bin);
    logic [FW:0] t;
    if (bin) t = {1'b0, v} + 9'd1;
    else     t = bcd_inc(v);
    return t[FW];
  endfunction

  // fixed month table, no leap years
  function automatic logic [FW-1:0] month_len(logic [FW-1:0] m, logic bin);
    int n;
    int d;
    n = fld_to_int(m, bin);
    case (n)
      1, 3, 5, 7, 8, 10, 12: d = 31;
      4, 6, 9, 11:           d = 30;
      2:                     d = 28;
      default:               d = 30;
    endcase
    return int_to_fld(d, bin);
  endfunction

  // 12-hour dial with PM flag -> 0..23 count
  function automatic logic [FW-1:0] hour_to24(logic [FW-1:0] v, logic h24, logic bin);
    int n;
    if (h24) return v;
    n = fld_to_int({1'b0, v[6:0]}, bin);
    if (v[7]) n = n + 12;
    return int_to_fld(n, bin);
  endfunction

  // 0..23 count -> dial format
  function automatic logic [FW-1:0] hour_from24(logic [FW-1:0] v, logic h24, logic bin);
    int n;
    if (h24) return v;
    n = fld_to_int(v, bin);
    if (n < 12) return v;
    return int_to_fld(n - 12, bin) | 8'h80;
  endfunction
endpackage

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
(
  input  logic [FW-1:0] sec_q,
  input  logic [FW-1:0] min_q,
  input  logic [FW-1:0] hour_q,
  input  logic          bin,
  input  logic          h24,
  output logic [FW-1:0] sec_n,
  output logic [FW-1:0] min_n,
  output logic [FW-1:0] hour_n,
  output logic          sec_wrap,
  output logic          min_wrap,
  output logic          day_carry
);
  logic [FW-1:0] s_inc;
  logic [FW-1:0] m_inc;
  logic [FW-1:0] h_lin;
  logic [FW-1:0] h_inc;
  logic [FW-1:0] h_lin_n;
  logic          h_full;

  always_comb begin
    s_inc    = step_val(sec_q, bin);
    sec_wrap = (s_inc == int_to_fld(60, bin));
    sec_n    = sec_wrap ? '0 : s_inc;

    m_inc    = step_val(min_q, bin);
    min_wrap = sec_wrap && (m_inc == int_to_fld(60, bin));
    if (!sec_wrap)     min_n = min_q;
    else if (min_wrap) min_n = '0;
    else               min_n = m_inc;

    h_lin    = hour_to24(hour_q, h24, bin);
    h_inc    = step_val(h_lin, bin);
    h_full   = (h_inc == int_to_fld(24, bin));
    h_lin_n  = h_full ? '0 : h_inc;
    hour_n   = min_wrap ? hour_from24(h_lin_n, h24, bin) : hour_q;
    day_carry = min_wrap && h_full;
  end
endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic [FW-1:0] wday_q,
  input  logic [FW-1:0] mday_q,
  input  logic [FW-1:0] mon_q,
  input  logic [FW-1:0] year_q,
  input  logic [FW-1:0] cent_q,
  input  logic          bin,
  input  logic          day_carry,
  output logic [FW-1:0] wday_n,
  output logic [FW-1:0] mday_n,
  output logic [FW-1:0] mon_n,
  output logic [FW-1:0] year_n,
  output logic [FW-1:0] cent_n,
  output logic          mon_roll,
  output logic          year_roll
);
  logic [FW-1:0] wd_inc;
  logic [FW-1:0] md_inc;
  logic [FW-1:0] mo_inc;
  logic [FW-1:0] yr_inc;
  logic          at_month_end;
  logic          mon_over;
  logic          yr_over;

  always_comb begin
    wd_inc = step_val(wday_q, bin);
    wday_n = day_carry ? ((wd_inc == int_to_fld(7, bin)) ? '0 : wd_inc) : wday_q;

    at_month_end = (mday_q == month_len(mon_q, bin));
    md_inc   = step_val(mday_q, bin);
    mon_roll = day_carry && at_month_end;
    if (!day_carry)    mday_n = mday_q;
    else if (mon_roll) mday_n = int_to_fld(1, bin);
    else               mday_n = md_inc;

    mo_inc   = step_val(mon_q, bin);
    mon_over = (mo_inc == int_to_fld(13, bin));
    if (!mon_roll)     mon_n = mon_q;
    else if (mon_over) mon_n = int_to_fld(1, bin);
    else               mon_n = mo_inc;

    yr_inc  = step_val(year_q, bin);
    yr_over = bin ? (yr_inc == int_to_fld(100, bin)) : step_cy(year_q, bin);
    if (!(mon_roll && mon_over)) year_n = year_q;
    else if (yr_over)            year_n = '0;
    else                         year_n = yr_inc;

    year_roll = mon_roll && mon_over && yr_over;
    cent_n    = year_roll ? step_val(cent_q, bin) : cent_q;
  end
endmodule

// File: rtl/cal_tick_counter.sv
module cal_tick_counter
  import cal_pkg::*;
#(
  parameter logic [FW-1:0] RST_SEC  = 8'h00,
  parameter logic [FW-1:0] RST_MIN  = 8'h00,
  parameter logic [FW-1:0] RST_HOUR = 8'h00,
  parameter logic [FW-1:0] RST_WDAY = 8'h01,
  parameter logic [FW-1:0] RST_MDAY = 8'h01,
  parameter logic [FW-1:0] RST_MON  = 8'h01,
  parameter logic [FW-1:0] RST_YEAR = 8'h08,
  parameter logic [FW-1:0] RST_CENT = 8'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            bin_mode_i,
  input  logic            h24_i,
  input  logic            ld_en_i,
  input  logic [SELW-1:0] ld_sel_i,
  input  logic [FW-1:0]   ld_data_i,
  output logic [FW-1:0]   sec_o,
  output logic [FW-1:0]   min_o,
  output logic [FW-1:0]   hour_o,
  output logic [FW-1:0]   wday_o,
  output logic [FW-1:0]   mday_o,
  output logic [FW-1:0]   mon_o,
  output logic [FW-1:0]   year_o,
  output logic [FW-1:0]   cent_o,
  output logic [FW-1:0]   cent_alt_o
);
  localparam logic [NF*FW-1:0] RST_VEC =
    {RST_CENT, RST_YEAR, RST_MON, RST_MDAY, RST_WDAY, RST_HOUR, RST_MIN, RST_SEC};

  logic [FW-1:0] fld_q [NF];
  logic [FW-1:0] fld_n [NF];
  logic [FW-1:0] cent_alt_q;

  // named events for the checker
  logic tick_eff;
  logic sec_wrap;
  logic min_wrap;
  logic day_carry;
  logic mon_roll;
  logic year_roll;

  assign tick_eff = tick_i && !ld_en_i;   // a load drops the tick

  cal_time_chain u_time (
    .sec_q    (fld_q[F_SEC]),
    .min_q    (fld_q[F_MIN]),
    .hour_q   (fld_q[F_HOUR]),
    .bin      (bin_mode_i),
    .h24      (h24_i),
    .sec_n    (fld_n[F_SEC]),
    .min_n    (fld_n[F_MIN]),
    .hour_n   (fld_n[F_HOUR]),
    .sec_wrap (sec_wrap),
    .min_wrap (min_wrap),
    .day_carry(day_carry)
  );

  cal_date_chain u_date (
    .wday_q   (fld_q[F_WDAY]),
    .mday_q   (fld_q[F_MDAY]),
    .mon_q    (fld_q[F_MON]),
    .year_q   (fld_q[F_YEAR]),
    .cent_q   (fld_q[F_CENT]),
    .bin      (bin_mode_i),
    .day_carry(day_carry),
    .wday_n   (fld_n[F_WDAY]),
    .mday_n   (fld_n[F_MDAY]),
    .mon_n    (fld_n[F_MON]),
    .year_n   (fld_n[F_YEAR]),
    .cent_n   (fld_n[F_CENT]),
    .mon_roll (mon_roll),
    .year_roll(year_roll)
  );

  for (genvar gi = 0; gi < NF; gi++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    fld_q[gi] <= RST_VEC[gi*FW +: FW];
      else if (ld_en_i && ld_sel_i == SELW'(gi))     fld_q[gi] <= ld_data_i;
      else if (tick_eff)                             fld_q[gi] <= fld_n[gi];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   cent_alt_q <= RST_CENT;
    else if (ld_en_i && ld_sel_i == F_CENT)       cent_alt_q <= ld_data_i;
    else if (tick_eff)                            cent_alt_q <= fld_n[F_CENT];
  end

  assign sec_o      = fld_q[F_SEC];
  assign min_o      = fld_q[F_MIN];
  assign hour_o     = fld_q[F_HOUR];
  assign wday_o     = fld_q[F_WDAY];
  assign mday_o     = fld_q[F_MDAY];
  assign mon_o      = fld_q[F_MON];
  assign year_o     = fld_q[F_YEAR];
  assign cent_o     = fld_q[F_CENT];
  assign cent_alt_o = cent_alt_q;
endmodule

// File: rtl/cal_counter_chk.sv
module cal_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       ld_en_i,
  input logic [2:0] ld_sel_i,
  input logic [7:0] ld_data_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] mday_o,
  input logic [7:0] year_o,
  input logic [7:0] cent_o,
  input logic [7:0] cent_alt_o,
  input logic       sec_wrap,
  input logic       day_carry,
  input logic       mon_roll,
  input logic       year_roll
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ld_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(year_o))); // R2

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_en_i && sec_wrap) |=> (sec_o == 8'h00)); // R3

  AST_DAY_HOUR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_en_i && day_carry) |=> (hour_o == 8'h00)); // R6

  AST_MONTH_DAY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_en_i && mon_roll) |=> (mday_o == 8'h01)); // R9

  AST_YEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_en_i && year_roll) |=> (year_o == 8'h00)); // R10

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en_i && ld_sel_i == 3'd0) |=> (sec_o == $past(ld_data_i))); // R11

  AST_CENT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (cent_o == cent_alt_o)); // R12
endmodule

bind cal_tick_counter cal_counter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .ld_en_i   (ld_en_i),
  .ld_sel_i  (ld_sel_i),
  .ld_data_i (ld_data_i),
  .sec_o     (sec_o),
  .min_o     (min_o),
  .hour_o    (hour_o),
  .mday_o    (mday_o),
  .year_o    (year_o),
  .cent_o    (cent_o),
  .cent_alt_o(cent_alt_o),
  .sec_wrap  (sec_wrap),
  .day_carry (day_carry),
  .mon_roll  (mon_roll),
  .year_roll (year_roll)
);

// File: tb/sim_cal_tick_counter.sv
`timescale 1ns/1ps
module sim_cal_tick_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       bin_mode_i = 1'b0;
  logic       h24_i = 1'b1;
  logic       ld_en_i = 1'b0;
  logic [2:0] ld_sel_i = 3'd0;
  logic [7:0] ld_data_i = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, cent_o, cent_alt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m [8];     // model fields: sec,min,hour,wday,mday,mon,year,cent
  logic [7:0] m_calt;

  always #2.5 clk = ~clk;

  cal_tick_counter u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bin_mode_i(bin_mode_i), .h24_i(h24_i),
    .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_data_i(ld_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o),
    .mon_o(mon_o), .year_o(year_o), .cent_o(cent_o), .cent_alt_o(cent_alt_o)
  );

  // ---------------- reference arithmetic, in plain integers ----------------
  function automatic int dv(logic [7:0] v);
    return bin_mode_i ? int'(v) : (int'(v >> 4) * 10 + int'(v & 8'h0f));
  endfunction

  function automatic logic [7:0] ev(int n);
    return bin_mode_i ? 8'(n) : 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int days_of(int mo);
    if (mo == 2) return 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    if (mo == 1 || mo == 3 || mo == 5 || mo == 7 || mo == 8 || mo == 10 || mo == 12) return 31;
    return 30;
  endfunction

  task automatic model_tick();
    int s, mi, h, c;
    s = dv(m[0]) + 1;
    if (s < 60) begin m[0] = ev(s); return; end
    m[0] = 8'h00;
    mi = dv(m[1]) + 1;
    if (mi < 60) begin m[1] = ev(mi); return; end
    m[1] = 8'h00;
    if (h24_i) h = dv(m[2]);
    else       h = dv(m[2] & 8'h7f) + (m[2][7] ? 12 : 0);
    h = (h + 1) % 24;
    if (h24_i || h < 12) m[2] = ev(h);
    else                 m[2] = ev(h - 12) | 8'h80;
    if (h != 0) return;
    m[3] = ev((dv(m[3]) + 1) % 7);
    if (dv(m[4]) != days_of(dv(m[5]))) begin m[4] = ev(dv(m[4]) + 1); return; end
    m[4] = ev(1);
    if (dv(m[5]) != 12) begin m[5] = ev(dv(m[5]) + 1); return; end
    m[5] = ev(1);
    if (dv(m[6]) != 99) begin m[6] = ev(dv(m[6]) + 1); return; end
    m[6] = 8'h00;
    c = dv(m[7]) + 1;
    m[7] = bin_mode_i ? 8'(c) : ev(c % 100);
    m_calt = m[7];
  endtask

  function automatic logic [71:0] got_all();
    return {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, cent_o, cent_alt_o};
  endfunction

  function automatic logic [71:0] exp_all();
    return {m[0], m[1], m[2], m[3], m[4], m[5], m[6], m[7], m_calt};
  endfunction

  task automatic check_all(string tag);
    checks++;
    if (got_all() !== exp_all()) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got_all(), exp_all());
    end
  endtask

  task automatic check_byte(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock: drive at falling edge, sample 1 ns after rising edge
  task automatic cyc(bit tk, bit ld, int sel, logic [7:0] d, string tag);
    @(negedge clk);
    tick_i = tk; ld_en_i = ld; ld_sel_i = 3'(sel); ld_data_i = d;
    @(posedge clk);
    #1;
    if (ld) begin
      m[sel] = d;
      if (sel == 7) m_calt = d;
    end else if (tk) begin
      model_tick();
    end
    check_all(tag);
  endtask

  task automatic load_all(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] w,
                          logic [7:0] md, logic [7:0] mo, logic [7:0] y, logic [7:0] c);
    cyc(0, 1, 0, s,  "R11 load");
    cyc(0, 1, 1, mi, "R11 load");
    cyc(0, 1, 2, h,  "R11 load");
    cyc(0, 1, 3, w,  "R11 load");
    cyc(0, 1, 5, mo, "R11 load");
    cyc(0, 1, 4, md, "R11 load");
    cyc(0, 1, 6, y,  "R11 load");
    cyc(0, 1, 7, c,  "R12 load");
  endtask

  task automatic set_mode(bit b, bit h);
    @(negedge clk);
    tick_i = 1'b0; ld_en_i = 1'b0;
    bin_mode_i = b; h24_i = h;
  endtask

  function automatic logic [7:0] rand_val(int f, bit edge_pick);
    int r;
    r = int'($urandom % 100);
    case (f)
      0, 1: return ev(edge_pick ? 59 : r % 60);
      2: begin
        if (h24_i) return ev(edge_pick ? 23 : r % 24);
        if (edge_pick) return ev(11) | 8'h80;
        return ev(r % 12) | (($urandom % 2) ? 8'h80 : 8'h00);
      end
      3: return ev(edge_pick ? 6 : r % 7);
      4: return ev(edge_pick ? days_of(dv(m[5])) : 1 + r % 28);
      5: return ev(edge_pick ? 12 : 1 + r % 12);
      6: return ev(edge_pick ? 99 : r);
      default: return ev(edge_pick ? 99 : 19 + r % 3);
    endcase
  endfunction

  // watchdog
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
    m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h08; m[7] = 8'h20; m_calt = 8'h20;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check_byte("R1 year", year_o, 8'h08);
    check_byte("R1 century mirror", cent_alt_o, 8'h20);

    // R2: idle cycles hold everything
    cyc(0, 0, 0, 8'h00, "R2 idle");
    cyc(0, 0, 3, 8'h55, "R2 idle");

    // R4: BCD nibble carry
    set_mode(0, 1);
    cyc(0, 1, 0, 8'h09, "R11 load");
    cyc(1, 0, 0, 8'h00, "R4 bcd tick");
    check_byte("R4 0x09->0x10", sec_o, 8'h10);

    // R3: seconds wrap carries into minutes
    cyc(0, 1, 0, 8'h59, "R11 load");
    cyc(0, 1, 1, 8'h00, "R11 load");
    cyc(1, 0, 0, 8'h00, "R3 sec wrap");
    check_byte("R3 min carry", min_o, 8'h01);

    // R5: binary increment
    set_mode(1, 1);
    load_all(8'd9, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd8, 8'd20);
    cyc(1, 0, 0, 8'h00, "R5 binary tick");
    check_byte("R5 9->10", sec_o, 8'h0a);

    // R6/R8/R9: 24h day end, weekday 6 wraps, Feb 28 -> Mar 1 (binary)
    load_all(8'd59, 8'd59, 8'd23, 8'd6, 8'd28, 8'd2, 8'd8, 8'd20);
    cyc(1, 0, 0, 8'h00, "R6 R8 R9 day end");
    check_byte("R6 hour 0", hour_o, 8'h00);
    check_byte("R8 weekday wrap", wday_o, 8'h00);
    check_byte("R9 feb end", mon_o, 8'd3);

    // R9: Apr 30 -> May 1, Jan 30 -> Jan 31 (BCD)
    set_mode(0, 1);
    load_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10, 8'h20);
    cyc(1, 0, 0, 8'h00, "R9 april end");
    check_byte("R9 may", mon_o, 8'h05);
    load_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h10, 8'h20);
    cyc(1, 0, 0, 8'h00, "R9 jan 30");
    check_byte("R9 day 31", mday_o, 8'h31);

    // R10: full cascade in BCD and in binary
    load_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99, 8'h19);
    cyc(1, 0, 0, 8'h00, "R10 bcd cascade");
    check_byte("R10 century", cent_o, 8'h20);
    check_byte("R10 century mirror", cent_alt_o, 8'h20);
    set_mode(1, 1);
    load_all(8'd59, 8'd59, 8'd23, 8'd3, 8'd31, 8'd12, 8'd99, 8'd20);
    cyc(1, 0, 0, 8'h00, "R10 binary cascade");
    check_byte("R10 binary century", cent_o, 8'd21);

    // R7: 12-hour dial, BCD
    set_mode(0, 0);
    load_all(8'h59, 8'h59, 8'h11, 8'h01, 8'h05, 8'h06, 8'h20, 8'h20);
    cyc(1, 0, 0, 8'h00, "R7 am to pm");
    check_byte("R7 noon", hour_o, 8'h80);
    load_all(8'h59, 8'h59, 8'h91, 8'h01, 8'h05, 8'h06, 8'h20, 8'h20);
    cyc(1, 0, 0, 8'h00, "R7 pm to am");
    check_byte("R7 midnight", hour_o, 8'h00);
    check_byte("R7 day carry", mday_o, 8'h06);

    // R11: load and tick together, tick dropped
    cyc(1, 1, 0, 8'h42, "R11 load beats tick");
    check_byte("R11 loaded", sec_o, 8'h42);
    cyc(1, 1, 3, 8'h04, "R11 other field holds");
    check_byte("R11 seconds unchanged", sec_o, 8'h42);

    // R12: century load writes both
    cyc(0, 1, 7, 8'h21, "R12 century load");
    check_byte("R12 mirror", cent_alt_o, 8'h21);

    // random phases across all mode combinations
    for (int ph = 0; ph < 4; ph++) begin
      set_mode(ph[0], ph[1]);
      load_all(rand_val(0, 1), rand_val(1, 1), rand_val(2, 1), rand_val(3, 0),
               8'h01, rand_val(5, 1), rand_val(6, 1), rand_val(7, 0));
      for (int k = 0; k < 600; k++) begin
        int r;
        int f;
        r = int'($urandom % 16);
        f = int'($urandom % 8);
        if (r == 0)      cyc(0, 1, f, rand_val(f, ($urandom % 2) == 1), "R11 random load");
        else if (r == 1) cyc(1, 1, f, rand_val(f, 1), "R11 random load with tick");
        else if (r < 14) cyc(1, 0, 0, 8'h00, "R3/R6/R9 random tick");
        else             cyc(0, 0, 0, 8'h00, "R2 random idle");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule